// File: doc/BRIEF.md
# Hall Six-Step Commutation Sequencer

This block converts the three Hall sensor bits of a brushless motor into six gate commands for a three-phase bridge, using 120-degree trapezoidal drive. In every valid rotor sector it energises exactly one high-side switch and one low-side switch of two different phases. One of the pair is held steadily on, and the other is chopped by a shared PWM carrier bit. The remaining four switches stay off. Which device is chopped alternates from sector to sector: even steps chop a low-side switch and odd steps chop a high-side switch. This spreads the switching losses over both halves of the bridge.

The Hall bits are first resynchronised. A new sector is adopted only on a PWM period boundary strobe, so a sector change never cuts a PWM pulse short. The Hall codes with all bits equal are treated as a sensor fault: every switch is turned off and a fault flag is raised. An enable input turns every switch off at once. Dead-time insertion and any speed or current regulation belong to the surrounding logic.

Top module: `hall_commutator`

## Requirements
- R1: The Hall code is hall_i = {HS3, HS2, HS1}, and bit p of top_o or bot_o drives phase p+1. With the carrier high, code 3'b001 gives top_o=3'b010, bot_o=3'b001. Code 3'b100 gives top_o=3'b100, bot_o=3'b010. Code 3'b010 gives top_o=3'b001, bot_o=3'b100. In these sectors the low-side switch is the chopped one.
- R2: With the carrier high, code 3'b101 gives top_o=3'b100, bot_o=3'b001. Code 3'b110 gives top_o=3'b001, bot_o=3'b010. Code 3'b011 gives top_o=3'b010, bot_o=3'b100. In these sectors the high-side switch is the chopped one.
- R3: Codes 3'b000 and 3'b111 drive all six outputs low and set fault_o. fault_o clears once a valid code has been adopted.
- R4: hall_i passes through a two-flop synchronizer. The decoded sector is adopted only on a cycle with period_tick_i high. Without a tick, changes on hall_i leave the outputs unchanged.
- R5: With en_i low, all six outputs are low one cycle later. fault_o is unaffected by en_i.
- R6: top_o[p] and bot_o[p] are never both high. At most one bit of top_o and at most one bit of bot_o is high.
- R7: After reset, all gate outputs and fault_o are low.
- R8: The chopped switch follows pwm_i with one cycle of latency. The steady switch stays high whatever the value of pwm_i.
- R9: Stepping through the forward sequence 1, 5, 4, 6, 2, 3 produces the R1/R2 pattern at every step. Each step moves exactly one of the two active switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Drive enable; low turns all switches off |
| hall_i | input | 3 | Hall bits {HS3, HS2, HS1}, asynchronous |
| pwm_i | input | 1 | Shared PWM carrier bit |
| period_tick_i | input | 1 | One-cycle strobe at the PWM period boundary |
| top_o | output | 3 | High-side gate commands, bit p = phase p+1 |
| bot_o | output | 3 | Low-side gate commands, bit p = phase p+1 |
| fault_o | output | 1 | Invalid Hall code adopted |

## Verification
A period boundary that adopts a new sector can arrive in the same cycle as a carrier transition. The registered gate stage must then apply the new carrier level to the old sector in that cycle, and the new sector only in the cycle after. The bench pre-synchronises a new code and then raises the tick and flips pwm_i on the same clock. It compares both following output samples against the pattern computed from the old and new codes. The same clash is also provoked between the tick and a drop of en_i, where the off state must win immediately.

// File: rtl/hall_seq_pkg.sv
package hall_seq_pkg;
  localparam int PHASES = 3;
  localparam int HALL_W = 3;

  typedef struct packed {
    logic [PHASES-1:0] top;      // active high-side switch (one-hot)
    logic [PHASES-1:0] bot;      // active low-side switch (one-hot)
    logic              chop_top; // 1: high side chopped, 0: low side chopped
    logic              bad;      // invalid sensor code
  } drive_pat_t;

  localparam drive_pat_t PAT_IDLE = '{top: '0, bot: '0, chop_top: 1'b0, bad: 1'b0};
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hall_decode.sv
module hall_decode
  import hall_seq_pkg::*;
(
  input  logic [HALL_W-1:0] code_i,
  output drive_pat_t        pat_o
);
  always_comb begin
    pat_o = PAT_IDLE;
    unique case (code_i)
      3'b001: begin pat_o.top = 3'b010; pat_o.bot = 3'b001; pat_o.chop_top = 1'b0; end
      3'b101: begin pat_o.top = 3'b100; pat_o.bot = 3'b001; pat_o.chop_top = 1'b1; end
      3'b100: begin pat_o.top = 3'b100; pat_o.bot = 3'b010; pat_o.chop_top = 1'b0; end
      3'b110: begin pat_o.top = 3'b001; pat_o.bot = 3'b010; pat_o.chop_top = 1'b1; end
      3'b010: begin pat_o.top = 3'b001; pat_o.bot = 3'b100; pat_o.chop_top = 1'b0; end
      3'b011: begin pat_o.top = 3'b010; pat_o.bot = 3'b100; pat_o.chop_top = 1'b1; end
      default: pat_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/sector_latch.sv
module sector_latch
  import hall_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  drive_pat_t pat_i,
  output drive_pat_t pat_o
);
  always_ff @(posedge clk) begin
    if (rst) pat_o <= PAT_IDLE;
    else if (tick_i) pat_o <= pat_i;
  end

  // R4: sector held between period boundaries
  p_sector_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pat_o));
endmodule

// File: rtl/gate_driver.sv
module gate_driver
  import hall_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              pwm_i,
  input  drive_pat_t        pat_i,
  output logic [PHASES-1:0] top_o,
  output logic [PHASES-1:0] bot_o
);
  logic [PHASES-1:0] top_d, bot_d;

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
      assign top_d[p] = en_i && pat_i.top[p] && (pat_i.chop_top ? pwm_i : 1'b1);
      assign bot_d[p] = en_i && pat_i.bot[p] && (pat_i.chop_top ? 1'b1 : pwm_i);

      // R6: no shoot-through within a phase leg
      p_no_shoot_r6: assert property (@(posedge clk) disable iff (rst)
        !(top_o[p] && bot_o[p]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      top_o <= '0;
      bot_o <= '0;
    end else begin
      top_o <= top_d;
      bot_o <= bot_d;
    end
  end

  // R6: at most one high-side and one low-side switch on
  p_single_pair_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(top_o) && $onehot0(bot_o));

  // R5: disable turns every switch off on the next cycle
  p_disable_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (top_o == '0 && bot_o == '0));

  // R3: an invalid sector yields no drive
  p_fault_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    pat_i.bad |=> (top_o == '0 && bot_o == '0));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [HALL_W-1:0] hall_i,
  input  logic              pwm_i,
  input  logic              period_tick_i,
  output logic [PHASES-1:0] top_o,
  output logic [PHASES-1:0] bot_o,
  output logic              fault_o
);
  logic [HALL_W-1:0] hall_s;
  drive_pat_t        pat_next, pat_q;

  hall_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(hall_i), .q_o(hall_s)
  );

  hall_decode u_dec (.code_i(hall_s), .pat_o(pat_next));

  sector_latch u_latch (
    .clk(clk), .rst(rst), .tick_i(period_tick_i), .pat_i(pat_next), .pat_o(pat_q)
  );

  gate_driver u_drv (
    .clk(clk), .rst(rst), .en_i(en_i), .pwm_i(pwm_i), .pat_i(pat_q),
    .top_o(top_o), .bot_o(bot_o)
  );

  assign fault_o = pat_q.bad;
endmodule

// File: tb/hall_commutator_bench.sv
module hall_commutator_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, en_i, pwm_i, period_tick_i;
  logic [2:0] hall_i;
  logic [2:0] top_o, bot_o;
  logic       fault_o;

  int checks = 0;
  int fails  = 0;

  hall_commutator u_hall_commutator (
    .clk(clk), .rst(rst), .en_i(en_i), .hall_i(hall_i), .pwm_i(pwm_i),
    .period_tick_i(period_tick_i), .top_o(top_o), .bot_o(bot_o), .fault_o(fault_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // Expected {top, bot} from the requirement table (R1, R2, R3, R5)
  function automatic logic [5:0] expect_drive(input logic [2:0] code, input logic pwm, input logic en);
    logic [2:0] t, b;
    t = 3'b000; b = 3'b000;
    case (code)
      3'b001: begin t = 3'b010;         b = {2'b00, pwm};   end
      3'b100: begin t = 3'b100;         b = {1'b0, pwm, 1'b0}; end
      3'b010: begin t = 3'b001;         b = {pwm, 2'b00};   end
      3'b101: begin t = {pwm, 2'b00};   b = 3'b001;         end
      3'b110: begin t = {2'b00, pwm};   b = 3'b010;         end
      3'b011: begin t = {1'b0, pwm, 1'b0}; b = 3'b100;      end
      default: begin t = 3'b000; b = 3'b000; end
    endcase
    if (!en) begin t = 3'b000; b = 3'b000; end
    return {t, b};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_out(input string req, input logic [2:0] et, input logic [2:0] eb, input logic ef);
    checks++;
    if (top_o !== et || bot_o !== eb || fault_o !== ef) begin
      fails++;
      $display("FAIL %s: top=%b bot=%b fault=%b expected top=%b bot=%b fault=%b",
               req, top_o, bot_o, fault_o, et, eb, ef);
    end
    checks++;
    if ((top_o & bot_o) !== 3'b000) begin
      fails++;
      $display("FAIL R6: leg overlap top=%b bot=%b expected no common bit", top_o, bot_o);
    end
  endtask

  task automatic check_code(input string req, input logic [2:0] code);
    logic [5:0] e;
    e = expect_drive(code, pwm_i, en_i);
    check_out(req, e[5:3], e[2:0], (code == 3'b000 || code == 3'b111));
  endtask

  // Present a code, let it cross the synchronizer, adopt it on a tick
  task automatic adopt(input logic [2:0] code);
    hall_i = code;
    cyc(2);
    period_tick_i = 1'b1;
    cyc(1);
    period_tick_i = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    check_out("R7 reset", 3'b000, 3'b000, 1'b0);
  endtask

  task automatic t_table;
    logic [2:0] codes [6] = '{3'b001, 3'b100, 3'b010, 3'b101, 3'b110, 3'b011};
    for (int i = 0; i < 6; i++) begin
      pwm_i = 1'b1;
      adopt(codes[i]);
      check_code((i < 3) ? "R1 low-side chop, carrier high" : "R2 high-side chop, carrier high", codes[i]);
      pwm_i = 1'b0;
      cyc(1);
      check_code((i < 3) ? "R1 carrier low" : "R2 carrier low", codes[i]);
    end
  endtask

  task automatic t_pwm_follow;
    adopt(3'b110);
    for (int k = 0; k < 4; k++) begin
      pwm_i = k[0];
      cyc(1);
      check_code("R8 chop follows carrier", 3'b110);
    end
    adopt(3'b100);
    pwm_i = 1'b1; cyc(1);
    pwm_i = 1'b0; cyc(1);
    check_code("R8 steady side holds", 3'b100);
  endtask

  task automatic t_invalid;
    pwm_i = 1'b1;
    adopt(3'b000);
    check_code("R3 code 000", 3'b000);
    adopt(3'b111);
    check_code("R3 code 111", 3'b111);
    adopt(3'b011);
    check_code("R3 fault clears", 3'b011);
  endtask

  task automatic t_tick_gating;
    pwm_i = 1'b1;
    adopt(3'b001);
    hall_i = 3'b100;
    cyc(6);
    check_code("R4 no tick keeps sector", 3'b001);
    adopt(3'b101);
    hall_i = 3'b010;
    period_tick_i = 1'b1;
    cyc(1);
    period_tick_i = 1'b0;
    cyc(1);
    check_code("R4 synchronizer latency", 3'b101);
  endtask

  task automatic t_enable;
    pwm_i = 1'b1;
    adopt(3'b011);
    en_i = 1'b0;
    cyc(1);
    check_out("R5 disable", 3'b000, 3'b000, 1'b0);
    adopt(3'b111);
    check_out("R5 fault while disabled", 3'b000, 3'b000, 1'b1);
    adopt(3'b011);
    en_i = 1'b1;
    cyc(1);
    check_code("R5 re-enable", 3'b011);
  endtask

  task automatic t_rotation;
    logic [2:0] seq [6] = '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011};
    logic [5:0] prev, now;
    pwm_i = 1'b1;
    adopt(seq[5]);
    prev = {top_o, bot_o};
    for (int i = 0; i < 6; i++) begin
      adopt(seq[i]);
      check_code("R9 forward step", seq[i]);
      now = {top_o, bot_o};
      checks++;
      if ($countones(prev ^ now) != 2) begin
        fails++;
        $display("FAIL R9: step to %b changed %0d bits expected 2", seq[i], $countones(prev ^ now));
      end
      prev = now;
    end
  endtask

  task automatic t_collide;
    pwm_i = 1'b1;
    adopt(3'b001);
    hall_i = 3'b101;
    cyc(2);
    period_tick_i = 1'b1;
    pwm_i = 1'b0;
    cyc(1);
    period_tick_i = 1'b0;
    check_code("R4 R8 tick+carrier, old sector", 3'b001);
    cyc(1);
    check_code("R4 R8 tick+carrier, new sector", 3'b101);
    pwm_i = 1'b1;
    hall_i = 3'b100;
    cyc(2);
    period_tick_i = 1'b1;
    en_i = 1'b0;
    cyc(1);
    period_tick_i = 1'b0;
    check_out("R5 tick+disable", 3'b000, 3'b000, 1'b0);
    en_i = 1'b1;
    cyc(1);
    check_code("R5 R4 tick+disable recovery", 3'b100);
  endtask

  initial begin
    rst = 1'b1; en_i = 1'b1; pwm_i = 1'b0; period_tick_i = 1'b0; hall_i = 3'b001;
    cyc(3);
    t_reset;
    rst = 1'b0;
    cyc(1);
    t_reset;
    t_table;
    t_pwm_follow;
    t_invalid;
    t_tick_gating;
    t_enable;
    t_rotation;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule